// File: doc/BRIEF.md
# Framed 24-bit Serial Write Receiver

This block takes write frames from a three-wire serial port: a select line that is low for the whole frame, a serial clock, and one data line. It runs on a faster system clock. It brings all three port lines into that clock domain through two-flop synchronizers and finds serial-clock falling edges there. On each falling edge it shifts in one data bit, most significant bit first. When the 24th bit arrives, it places the assembled word on its output and raises a one-cycle valid strobe. A register bank further down the chip consumes that strobe and word.

A frame counts only if the select line stays low until the 24th falling edge. If the select line rises earlier, the frame is dropped. The partial word is thrown away, the bit counter clears, and the output does not change.

A mute input makes the receiver ignore the port completely, so other devices can use the shared lines. Raising mute during a frame drops that frame in the same way an early select rise does.

The output carries no back-pressure. There is no ready input, and the sink must accept every strobe in the cycle it appears. The system clock must run at least four times faster than the serial clock.

Top module: `ser24_rx`

## Requirements
- R1: While reset is held and after it is released, `word_valid` is 0 and `word_data` is 0 until the first completed frame.
- R2: A frame of 24 falling serial-clock edges yields a word whose bit 23 is the data bit taken at the first falling edge and whose bit 0 is the bit taken at the 24th.
- R3: The word is committed on the 24th falling edge itself, with `word_valid` high within four system cycles of that edge, while the select line is still low.
- R4: `word_valid` is high for exactly one system cycle per completed frame, and `word_data` changes only in a cycle where `word_valid` is high.
- R5: If the select line rises before the 24th falling edge, no strobe is issued and `word_data` keeps its previous value.
- R6: After an aborted frame, the next frame starts from an empty shift register and a zero bit count, and it delivers exactly its own 24 bits.
- R7: Falling edges after the 24th, while the select line stays low, are ignored. There is one strobe per frame, and the word holds the first 24 bits. A new frame needs the select line to rise and fall again.
- R8: While `rx_mute` is high, no frame is recognised and no strobe is issued.
- R9: Raising `rx_mute` for any time during a frame aborts that frame, even if mute drops before the 24th edge. Frames that start after mute is low again work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rx_mute | input | 1 | High: ignore the serial port, abort any frame in progress |
| ser_sck | input | 1 | Serial clock; data is taken on its falling edge |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_sdi | input | 1 | Serial data, most significant bit first |
| word_valid | output | 1 | One-cycle strobe marking a completed frame |
| word_data | output | BITS | Last completed word, held between strobes |

## Verification
A bit counter that does not clear on an abort shows up in the next frame. That frame then strobes early, with a word shifted by the stale count, within 24 serial-clock periods of its start. A stuck frame state shows up in one of two ways: a missing strobe about three system cycles after the 24th edge, or a second strobe from the extra edges of an over-long frame. The random frames mix lengths from 0 to 30 edges with mute pulses placed anywhere in the frame. A wrong decision about which frames count therefore appears as a strobe-count or word mismatch on the frame where it happens.

// File: rtl/ser24_pkg.sv
package ser24_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_HOLD  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/ser24_sync.sv
module ser24_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ser24_framer.sv
module ser24_framer
  import ser24_pkg::*;
#(
  parameter int unsigned BITS = 24,
  localparam int unsigned CW  = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mute,
  input  logic          sel_lvl,
  input  logic          sck_lvl,
  output logic          shift_en,
  output logic          commit,
  output logic          clear,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  fr_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sel_d, sck_d;
  logic          sel_fall, sck_fall;

  assign sel_fall = sel_d & ~sel_lvl;
  assign sck_fall = sck_d & ~sck_lvl;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    shift_en = 1'b0;
    commit   = 1'b0;
    clear    = 1'b0;
    unique case (state_q)
      FR_IDLE: begin
        if (!mute && sel_fall) begin
          state_n = FR_SHIFT;
          cnt_n   = '0;
          clear   = 1'b1;
        end
      end
      FR_SHIFT: begin
        if (mute || sel_lvl) begin
          state_n = FR_IDLE;
          cnt_n   = '0;
          clear   = 1'b1;
        end else if (sck_fall) begin
          shift_en = 1'b1;
          if (cnt_q == LAST) begin
            commit  = 1'b1;
            state_n = FR_HOLD;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      FR_HOLD: begin
        if (mute || sel_lvl) state_n = FR_IDLE;
      end
      default: begin
        state_n = FR_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      sel_d   <= 1'b1;
      sck_d   <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sel_d   <= sel_lvl;
      sck_d   <= sck_lvl;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ser24_shift.sv
module ser24_shift #(
  parameter int unsigned BITS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            commit,
  input  logic            din,
  output logic            valid_o,
  output logic [BITS-1:0] word_o
);
  logic [BITS-1:0] sr_q;
  logic [BITS-1:0] sr_next;

  assign sr_next = {sr_q[BITS-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= commit;
      if (clear)         sr_q <= '0;
      else if (shift_en) sr_q <= sr_next;
      if (commit)        word_o <= sr_next;
    end
  end
endmodule

// File: rtl/ser24_rx.sv
module ser24_rx #(
  parameter int unsigned BITS = 24,
  localparam int unsigned CW  = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_mute,
  input  logic            ser_sck,
  input  logic            ser_sel_n,
  input  logic            ser_sdi,
  output logic            word_valid,
  output logic [BITS-1:0] word_data
);
  logic [2:0]    port_sync;
  logic          sel_lvl, sck_lvl, sdi_lvl;
  logic          shift_en, commit, clear;
  logic [CW-1:0] bit_cnt;

  ser24_sync #(.W(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_sel_n, ser_sck, ser_sdi}),
    .sync_o  (port_sync)
  );

  assign {sel_lvl, sck_lvl, sdi_lvl} = port_sync;

  ser24_framer #(.BITS(BITS)) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mute     (rx_mute),
    .sel_lvl  (sel_lvl),
    .sck_lvl  (sck_lvl),
    .shift_en (shift_en),
    .commit   (commit),
    .clear    (clear),
    .cnt      (bit_cnt)
  );

  ser24_shift #(.BITS(BITS)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .shift_en (shift_en),
    .commit   (commit),
    .din      (sdi_lvl),
    .valid_o  (word_valid),
    .word_o   (word_data)
  );
endmodule

// File: rtl/ser24_rx_chk.sv
module ser24_rx_chk #(
  parameter int unsigned BITS = 24,
  localparam int unsigned CW  = $clog2(BITS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mute,
  input logic            sel_lvl,
  input logic            valid,
  input logic [BITS-1:0] word,
  input logic [CW-1:0]   cnt
);
  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> valid);

  // R8
  mute_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> !valid);

  // R5
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl |=> (cnt == '0));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < BITS);
endmodule

bind ser24_rx ser24_rx_chk #(.BITS(BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mute    (rx_mute),
  .sel_lvl (sel_lvl),
  .valid   (word_valid),
  .word    (word_data),
  .cnt     (bit_cnt)
);

// File: tb/sim_ser24_rx.sv
module sim_ser24_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BITS = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b0;
  logic sck = 1'b1;
  logic sel_n = 1'b1;
  logic sdi = 1'b0;
  logic            valid;
  logic [BITS-1:0] word;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser24_rx #(.BITS(BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_mute(mute), .ser_sck(sck),
    .ser_sel_n(sel_n), .ser_sdi(sdi), .word_valid(valid), .word_data(word)
  );

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  int wide_pulse = 0;
  int stray_change = 0;
  logic [BITS-1:0] last_word = '0;
  logic [BITS-1:0] prev_word = '0;
  logic prev_valid = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        pulses++;
        last_word = word;
      end
      if (valid && prev_valid) wide_pulse++;
      if (word !== prev_word && !valid) stray_change++;
      prev_valid = valid;
      prev_word = word;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_commit(input int n, input int mute_at, input bit mute_all);
    return !mute_all && n >= BITS && (mute_at < 0 || mute_at >= BITS);
  endfunction

  // bits[31] is sent first; a full frame delivers bits[31:8]
  task automatic frame(input logic [31:0] bits, input int n, input int mute_at,
                       input bit mute_all, input string tag);
    int base;
    int early;
    int got;
    bit expc;
    logic [BITS-1:0] wbase;
    logic [BITS-1:0] wexp;
    base = pulses;
    wbase = last_word;
    early = -1;
    expc = exp_commit(n, mute_at, mute_all);
    wexp = expc ? bits[31:8] : wbase;
    if (mute_all) begin mute = 1'b1; wait_n(2); end
    sel_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < n; i++) begin
      if (i == mute_at) begin mute = 1'b1; wait_n(3); mute = 1'b0; wait_n(1); end
      sdi = bits[31 - i];
      wait_n(2);
      sck = 1'b0;
      wait_n(4);
      sck = 1'b1;
      wait_n(2);
      if (i == BITS - 1) early = pulses - base;
    end
    wait_n(2);
    sel_n = 1'b1;
    wait_n(10);
    if (mute_all) begin mute = 1'b0; wait_n(2); end
    got = pulses - base;
    check(got == (expc ? 1 : 0), {tag, " strobe count"}, got, expc ? 1 : 0);
    check(word === wexp, {tag, " word"}, word, wexp);
    if (expc) check(early == 1, "R3 strobe before select rises", early, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    wait_n(3);
    check(valid === 1'b0, "R1 strobe in reset", valid, 0);
    check(word === '0, "R1 word in reset", word, 0);
    rst_n = 1'b1;
    wait_n(4);
    check(valid === 1'b0, "R1 strobe after reset", valid, 0);
    check(word === '0, "R1 word after reset", word, 0);

    frame(32'hA5C30F00, 24, -1, 1'b0, "R2 pattern");
    frame(32'h80000100, 24, -1, 1'b0, "R2 end bits");
    frame(32'h12345600, 23, -1, 1'b0, "R5 abort at 23");
    frame(32'hFFFFFF00, 1, -1, 1'b0, "R5 abort at 1");
    frame(32'h00000000, 0, -1, 1'b0, "R5 empty frame");
    frame(32'hFFFFFF00, 24, -1, 1'b0, "R6 after abort");
    frame(32'h5A5A5A5A, 12, -1, 1'b0, "R5 abort at 12");
    frame(32'h3C3C3C00, 24, -1, 1'b0, "R6 clean restart");
    frame(32'hC0FFEE6B, 30, -1, 1'b0, "R7 extra edges");
    frame(32'h0F0F0F00, 24, -1, 1'b1, "R8 muted frame");
    frame(32'h77665500, 24, 10, 1'b0, "R9 mute mid frame");
    frame(32'h11223300, 24, 0, 1'b0, "R9 mute at start");
    frame(32'h99887700, 24, -1, 1'b0, "R9 after mute");

    for (int k = 0; k < 70; k++) begin
      logic [31:0] bits;
      int n;
      int mat;
      bit mall;
      bits = $urandom;
      n = ($urandom_range(1, 0) == 1) ? int'($urandom_range(30, 24)) : int'($urandom_range(30, 0));
      mat = ($urandom_range(5, 0) == 0) ? int'($urandom_range(n, 0)) : -1;
      mall = ($urandom_range(7, 0) == 0);
      frame(bits, n, mat, mall, "R2 R5 R9 random");
    end

    check(wide_pulse == 0, "R4 strobe width", wide_pulse, 0);
    check(stray_change == 0, "R4 word held between strobes", stray_change, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule